// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block gives a processor three independent 16-bit down-counters behind an 8-bit register port. Each channel has its own count clock input and its own output pin. Software first writes a control word. The control word names a channel and picks the counting mode, binary or BCD counting, and how the 16-bit count is moved over the 8-bit bus. Software then writes the count. From then on the channel counts on the falling edges of its count clock and drives its output with one of four waveforms: a terminal-count level, a periodic one-tick pulse, a square wave, or a single one-tick strobe.

All logic runs on the system clock `clk`. Each count clock is passed through a synchronizer of `SYNC_STAGES` flops and then an edge detector. A falling edge sampled at system edge k acts on the channel at edge k+2 when the default of two stages is used. A running count can be frozen into a holding register with a latch command and then read back one byte at a time while the counter keeps running.

Each channel is a state machine with these states:
- S_IDLE: after reset; ignores ticks.
- S_WAIT: control word taken; waiting for the count.
- S_ARMED: count complete; waiting for the first tick.
- S_RUN: counting.
- S_STROBE: strobe mode, output low for one tick.
- S_HALT: terminal count passed; the counter keeps decrementing and the output is held.

The transitions are:
- program: any state to S_WAIT on a control write.
- load: any state to S_ARMED on the final count byte.
- start: S_ARMED to S_RUN on a tick.
- terminal: S_RUN to S_HALT in mode 0, or S_RUN to S_STROBE in mode 4, when a tick finds the count at 1.
- release: S_STROBE to S_HALT on the next tick.

In modes 2 and 3, S_RUN reloads itself.

Top module: `tri_interval_timer`

## Requirements
- R1: The `sel` input picks the register. Codes 0, 1 and 2 are the count registers of channels 0, 1 and 2, and these can be read and written. Code 3 is the control register. It is write-only, and a read of it returns 00h.
- R2: In a control word, bit 0 = 1 selects BCD counting. Bits 3:1 are the mode code, bits 5:4 the access type and bits 7:6 the channel. A channel field of 3 is ignored. The mode codes decode as follows: 0, 1 and 5 give mode 0; 2 and 6 give mode 2; 3 and 7 give mode 3; 4 gives mode 4.
- R3: The access type sets how count bytes move. 01 moves the low byte only, and a load clears the high byte. 10 moves the high byte only, and a load clears the low byte. 11 moves the low byte first, then the high byte. A loaded count of zero counts as 65536 in binary or 10000 in BCD.
- R4: A control word with access type 00 is a latch command. It freezes the channel's current count for reading while counting goes on. A second latch command before the frozen value has been fully read is ignored. Reading the last byte releases the latch. Without a latch, reads return the live count.
- R5: The first tick after the final byte of a count loads the count. This is tick 0. A tick that falls in the same system cycle as that byte does not count. Until tick 0, modes 2 and 3 keep their output unchanged.
- R6: Mode 0. The output goes low on a control write and again on a count load. It goes high at tick N and holds until the channel is reprogrammed or reloaded.
- R7: With BCD selected, the counter decrements in decimal. The count reads back as packed BCD digits, and the terminal tick is the decimal value N.
- R8: Mode 2 (N ≥ 2). The output is high from the control write. It is low from tick N−1 to tick N, and this repeats with a period of N ticks.
- R9: Mode 3 (N ≥ 2). Within each period of N ticks the output is high for (N+1)/2 ticks (integer division), starting at the reload, and low for the remaining ticks.
- R10: Mode 4. The output is high from the control write and from a count load. It is low from tick N to tick N+1 and is then high for good.
- R11: After reset every output is low, every count reads 0, and channels ignore count clocks until they are programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Register select (0–2 count registers, 3 control) |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, advances the byte order |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| cnt_clk | input | 3 | Count clock for each channel |
| tout | output | 3 | Output waveform for each channel |

## Verification
Two events can land on the same system edge: a count-clock tick, and the bus write that completes a count load. The bench places the falling count-clock edge exactly two cycles before the final byte write, so both act on the same edge. It then checks that the terminal output appears at the Nth of the later ticks and not one tick early. A latch command can also fall between ticks while the counter keeps moving. The frozen value must stay fixed through further ticks and through a repeated latch command, while the live count moves on.

// File: rtl/tit_pkg.sv
package tit_pkg;
    localparam int NUM_CH = 3;
    localparam int CNT_W  = 16;
    localparam int DIGITS = CNT_W / 4;
    localparam logic [1:0] SEL_CTRL = 2'b11;

    typedef enum logic [1:0] {MD_TERM, MD_RATE, MD_SQUARE, MD_STROBE} cnt_mode_e;
    typedef enum logic [1:0] {AC_LATCH = 2'b00, AC_LOW = 2'b01,
                              AC_HIGH = 2'b10, AC_WORD = 2'b11} access_e;
    typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ARMED, S_RUN, S_STROBE, S_HALT} ch_state_e;

    // Bit 2 of the code is ignored for the periodic modes; one-shot codes fold to mode 0.
    function automatic cnt_mode_e decode_mode(input logic [2:0] code);
        if (code[1])
            return code[0] ? MD_SQUARE : MD_RATE;
        else if (code == 3'b100)
            return MD_STROBE;
        else
            return MD_TERM;
    endfunction

    function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic borrow;
        if (!bcd) return v - 1'b1;
        r = v;
        borrow = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (borrow) begin
                if (v[4*d +: 4] == 4'd0) begin
                    r[4*d +: 4] = 4'd9;
                end else begin
                    r[4*d +: 4] = v[4*d +: 4] - 4'd1;
                    borrow = 1'b0;
                end
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/tit_edge_sync.sv
module tit_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic tick
);
    logic [STAGES-1:0] sr;
    logic              prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            prev <= 1'b0;
        end else begin
            sr   <= {sr[STAGES-2:0], raw};
            prev <= sr[STAGES-1];
        end
    end

    assign tick = prev & ~sr[STAGES-1];

    // R5: a falling edge produces a single-cycle tick
    a_r5_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tit_channel.sv
module tit_channel
    import tit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic             latch_cmd,
    input  logic [2:0]       cfg_mode,
    input  logic [1:0]       cfg_access,
    input  logic             cfg_bcd,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             tout
);
    ch_state_e        st, st_n;
    cnt_mode_e        mode;
    access_e          acc;
    logic             bcd;
    logic [CNT_W-1:0] reload, count, count_n, latch_val, rd_src;
    logic             out_q, out_n, extra, extra_n;
    logic             wr_hi, rd_hi, latched, load_done, hi_sel;

    assign load_done = data_wr && !ctrl_wr && ((acc != AC_WORD) || wr_hi);

    // next state, count and output
    always_comb begin
        st_n    = st;
        count_n = count;
        out_n   = out_q;
        extra_n = extra;
        if (ctrl_wr) begin
            st_n    = S_WAIT;
            out_n   = (decode_mode(cfg_mode) != MD_TERM);
            extra_n = 1'b0;
        end else if (load_done) begin
            st_n = S_ARMED;
            if (mode == MD_TERM)
                out_n = 1'b0;
            else if (mode == MD_STROBE)
                out_n = 1'b1;
        end else if (tick) begin
            unique case (st)
                S_IDLE, S_WAIT: begin
                end
                S_ARMED: begin
                    st_n    = S_RUN;
                    extra_n = 1'b0;
                    if (mode == MD_SQUARE) begin
                        count_n = {reload[CNT_W-1:1], 1'b0};
                        extra_n = reload[0];
                    end else begin
                        count_n = reload;
                    end
                    if (mode == MD_RATE || mode == MD_SQUARE)
                        out_n = 1'b1;
                end
                S_RUN: begin
                    unique case (mode)
                        MD_TERM: begin
                            count_n = cnt_dec(count, bcd);
                            if (count == 16'd1) begin
                                out_n = 1'b1;
                                st_n  = S_HALT;
                            end
                        end
                        MD_STROBE: begin
                            count_n = cnt_dec(count, bcd);
                            if (count == 16'd1) begin
                                out_n = 1'b0;
                                st_n  = S_STROBE;
                            end
                        end
                        MD_RATE: begin
                            if (count == 16'd1) begin
                                count_n = reload;
                                out_n   = 1'b1;
                            end else begin
                                count_n = cnt_dec(count, bcd);
                                if (count == 16'd2)
                                    out_n = 1'b0;
                            end
                        end
                        MD_SQUARE: begin
                            if (extra) begin
                                extra_n = 1'b0;
                            end else if (count == 16'd2) begin
                                out_n   = ~out_q;
                                count_n = {reload[CNT_W-1:1], 1'b0};
                                extra_n = reload[0] && !out_q;
                            end else begin
                                count_n = cnt_dec(cnt_dec(count, bcd), bcd);
                            end
                        end
                        default: begin
                        end
                    endcase
                end
                S_STROBE: begin
                    count_n = cnt_dec(count, bcd);
                    out_n   = 1'b1;
                    st_n    = S_HALT;
                end
                S_HALT: begin
                    count_n = cnt_dec(count, bcd);
                end
                default: st_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // datapath, configuration and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MD_TERM;
            acc       <= AC_WORD;
            bcd       <= 1'b0;
            reload    <= '0;
            count     <= '0;
            out_q     <= 1'b0;
            extra     <= 1'b0;
            wr_hi     <= 1'b0;
            rd_hi     <= 1'b0;
            latched   <= 1'b0;
            latch_val <= '0;
        end else begin
            count <= count_n;
            out_q <= out_n;
            extra <= extra_n;
            if (ctrl_wr) begin
                mode    <= decode_mode(cfg_mode);
                acc     <= access_e'(cfg_access);
                bcd     <= cfg_bcd;
                wr_hi   <= 1'b0;
                rd_hi   <= 1'b0;
                latched <= 1'b0;
            end else begin
                if (data_wr) begin
                    unique case (acc)
                        AC_HIGH: reload <= {wdata, 8'h00};
                        AC_WORD: begin
                            if (wr_hi) reload[15:8] <= wdata;
                            else       reload[7:0]  <= wdata;
                            wr_hi <= ~wr_hi;
                        end
                        default: reload <= {8'h00, wdata};
                    endcase
                end
                if (latch_cmd && !latched) begin
                    latched   <= 1'b1;
                    latch_val <= count;
                end
                if (data_rd) begin
                    if (acc == AC_WORD && !rd_hi) begin
                        rd_hi <= 1'b1;
                    end else begin
                        rd_hi   <= 1'b0;
                        latched <= 1'b0;
                    end
                end
            end
        end
    end

    assign rd_src = latched ? latch_val : count;
    assign hi_sel = (acc == AC_HIGH) || (acc == AC_WORD && rd_hi);
    assign rdata  = hi_sel ? rd_src[15:8] : rd_src[7:0];
    assign tout   = out_q;

    // R6: after the terminal count, mode 0 holds its output high
    a_r6_term_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HALT && mode == MD_TERM && !ctrl_wr && !load_done) |=> out_q);

    // R8: the rate-generator low pulse lasts one tick
    a_r8_rate_one_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && mode == MD_RATE && !out_q && tick && !ctrl_wr && !load_done) |=> out_q);

    // R10: the strobe ends on the next tick
    a_r10_strobe_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_STROBE && tick && !ctrl_wr && !load_done) |=> out_q);

    // R5: an armed channel waits for a tick with output and count untouched
    a_r5_armed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ARMED && !tick && !ctrl_wr && !load_done) |=>
            ($stable(out_q) && $stable(count) && st == S_ARMED));

    // R4: a latched value stays frozen until released
    a_r4_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !ctrl_wr) |=> $stable(latch_val));
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import tit_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [NUM_CH-1:0] cnt_clk,
    output logic [NUM_CH-1:0] tout
);
    logic       ctrl_hit;
    logic [7:0] ch_rdata [NUM_CH];

    assign ctrl_hit = wr_en && (sel == SEL_CTRL);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        logic tick_g;
        logic chan_hit;

        assign chan_hit = ctrl_hit && (wdata[7:6] == 2'(gi));

        tit_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (cnt_clk[gi]),
            .tick (tick_g)
        );

        tit_channel u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick_g),
            .ctrl_wr   (chan_hit && (wdata[5:4] != 2'b00)),
            .latch_cmd (chan_hit && (wdata[5:4] == 2'b00)),
            .cfg_mode  (wdata[3:1]),
            .cfg_access(wdata[5:4]),
            .cfg_bcd   (wdata[0]),
            .data_wr   (wr_en && (sel == 2'(gi))),
            .data_rd   (rd_en && (sel == 2'(gi))),
            .wdata     (wdata),
            .rdata     (ch_rdata[gi]),
            .tout      (tout[gi])
        );
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_CH; i++)
            if (sel == 2'(i)) rdata = ch_rdata[i];
    end
endmodule

// File: tb/tri_interval_timer_test.sv
module tri_interval_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] cnt_clk = 3'b111;
    logic [2:0] tout;

    int total = 0, fails = 0;
    bit done = 0;

    tri_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .cnt_clk(cnt_clk), .tout(tout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] s, output logic [7:0] b);
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        #1 b = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick(input int ch);
        @(negedge clk);
        cnt_clk[ch] = 1'b0;
        repeat (3) @(negedge clk);
        cnt_clk[ch] = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    function automatic int eff_mode(input int code);
        if (code % 4 == 2) return 2;
        if (code % 4 == 3) return 3;
        if (code == 4) return 4;
        return 0;
    endfunction

    function automatic logic exp_out(input int m, input int n, input int i);
        case (m)
            0: return i >= n;
            2: return !((i % n) == n - 1);
            3: return (i % n) < (n + 1) / 2;
            default: return i != n;
        endcase
    endfunction

    function automatic string req_of(input int m);
        case (m)
            0: return "R6";
            2: return "R8";
            3: return "R9";
            default: return "R10";
        endcase
    endfunction

    // program a channel (access 11, binary), load n and follow nt ticks
    task automatic run_pattern(input int ch, input int code, input int n, input int nt);
        int m;
        m = eff_mode(code);
        bus_wr(2'b11, {2'(ch), 2'b11, 3'(code), 1'b0});
        chk({req_of(m), "/R2 after control"}, tout[ch], (m != 0));
        bus_wr(2'(ch), n[7:0]);
        bus_wr(2'(ch), n[15:8]);
        chk({req_of(m), "/R5 before first tick"}, tout[ch], (m != 0));
        for (int i = 0; i <= nt; i++) begin
            tick(ch);
            chk($sformatf("%s/R2 code %0d n %0d tick %0d", req_of(m), code, n, i),
                tout[ch], exp_out(m, n, i));
        end
    endtask

    logic [7:0] b0, b1;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state, ticks ignored while unprogrammed
        chk("R11 outputs after reset", tout, 3'b000);
        bus_rd(2'b00, b0);
        chk("R11 count after reset", b0, 8'h00);
        tick(0); tick(0); tick(0);
        chk("R11 idle ignores ticks", tout, 3'b000);
        bus_rd(2'b00, b0);
        chk("R11 idle count still zero", b0, 8'h00);
        // R1: the control register reads as zero
        bus_rd(2'b11, b0);
        chk("R1 control reads zero", b0, 8'h00);

        // directed patterns, one per mode
        run_pattern(0, 0, 5, 8);   // R6
        bus_wr(2'b11, 8'hF0);      // R2: channel field 3 ignored
        chk("R2 channel 3 ignored", tout[0], 1'b1);
        bus_wr(2'b00, 8'h03);      // R6: reload drops output
        bus_wr(2'b00, 8'h00);
        chk("R6 reload drives low", tout[0], 1'b0);
        run_pattern(1, 4, 4, 8);   // R10
        run_pattern(2, 2, 4, 12);  // R8
        run_pattern(0, 3, 4, 10);  // R9 even
        run_pattern(1, 7, 5, 12);  // R9 odd, code 7 alias
        run_pattern(2, 5, 3, 5);   // R2 code 5 behaves as mode 0

        // R3: low byte only
        bus_wr(2'b11, 8'h50);
        bus_wr(2'b01, 8'h03);
        for (int i = 0; i <= 4; i++) begin
            tick(1);
            chk($sformatf("R3 low-only tick %0d", i), tout[1], (i >= 3));
        end
        // R3: high byte only, N = 256
        bus_wr(2'b11, 8'h60);
        bus_wr(2'b01, 8'h01);
        tick(1);
        bus_rd(2'b01, b0);
        chk("R3 high-only read", b0, 8'h01);
        for (int i = 1; i <= 256; i++) begin
            tick(1);
            if (i == 255) chk("R3 high-only before terminal", tout[1], 1'b0);
            if (i == 256) chk("R3 high-only at terminal", tout[1], 1'b1);
        end

        // R4: latch while counting
        bus_wr(2'b11, 8'hB0);
        bus_wr(2'b10, 8'h34);
        bus_wr(2'b10, 8'h12);
        for (int i = 0; i <= 5; i++) tick(2);
        bus_wr(2'b11, 8'h80);
        tick(2); tick(2); tick(2);
        bus_wr(2'b11, 8'h80);      // ignored: still latched
        bus_rd(2'b10, b0);
        bus_rd(2'b10, b1);
        chk("R4 latched low", b0, 8'h2F);
        chk("R4 latched high", b1, 8'h12);
        bus_rd(2'b10, b0);
        bus_rd(2'b10, b1);
        chk("R4 live low after release", b0, 8'h2C);
        chk("R4 live high after release", b1, 8'h12);

        // R7: BCD count 12
        bus_wr(2'b11, 8'h31);
        bus_wr(2'b00, 8'h12);
        bus_wr(2'b00, 8'h00);
        for (int i = 0; i <= 12; i++) begin
            tick(0);
            if (i == 3) begin
                bus_rd(2'b00, b0);
                bus_rd(2'b00, b1);
                chk("R7 BCD digits", {b1, b0}, 16'h0009);
            end
            if (i == 11) chk("R7 BCD before terminal", tout[0], 1'b0);
            if (i == 12) chk("R7 BCD terminal", tout[0], 1'b1);
        end

        // R5: final byte coincides with a tick
        bus_wr(2'b11, 8'h30);
        bus_wr(2'b00, 8'h03);
        @(negedge clk);
        cnt_clk[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        sel = 2'b00; wdata = 8'h00; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        cnt_clk[0] = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i <= 4; i++) begin
            tick(0);
            chk($sformatf("R5 coincident load tick %0d", i), tout[0], (i >= 3));
        end

        // constrained random patterns (R2 decode, R6/R8/R9/R10)
        for (int k = 0; k < 6; k++) begin
            int ch, code, n;
            ch   = int'($urandom % 3);
            code = int'($urandom % 8);
            n    = 2 + int'($urandom % 14);
            repeat (int'($urandom % 5)) @(negedge clk);
            run_pattern(ch, code, n, 2 * n + 2);
        end

        // R3: zero count in BCD means 10000
        bus_wr(2'b11, 8'h31);
        bus_wr(2'b00, 8'h00);
        bus_wr(2'b00, 8'h00);
        for (int i = 0; i <= 10000; i++) begin
            tick(0);
            if (i == 9999)  chk("R3 BCD zero before terminal", tout[0], 1'b0);
            if (i == 10000) chk("R3 BCD zero terminal", tout[0], 1'b1);
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule